// File: doc/BRIEF.md
# Pin I/O Bank with Grouped Interrupts

This block drives and senses a bank of general-purpose pins from a small word-addressed register port. Software picks each pin's direction, the level driven on output pins, an optional blink on output pins, and a per-pin polarity that flips how an input is read. Input pins pass through a two-stage synchroniser. The synchronised level is XORed with the polarity bit, and the result can be read back as the input data word.

Each pin can raise an interrupt in two ways. A level cause follows the polarity-adjusted input directly. An edge cause latches every 0-to-1 change of that adjusted value and holds it until software clears it. Because the polarity bit sits in front of both paths, a single rising-edge detector serves rising-edge, falling-edge and level-low sources. Both causes have their own enable words. The enabled causes are ORed together in groups of eight consecutive pins, and each group drives one interrupt line.

The register port is a plain single-cycle interface with no handshake: a write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally. Because it never stalls, there is no back-pressure to manage.

Top module: `gpio_irq_unit`

## Requirements
- R1: Byte offsets decode as follows: 0x00 drive level, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 input data (read-only), 0x14 edge cause, 0x18 edge enable, 0x1C level enable. Writable words read back the last value written. A write to 0x10 changes nothing.
- R2: A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe` is the bitwise inverse of the direction word, and an output pin shows its drive-level bit on `pin_out`. After reset every pin is an input.
- R3: The input data word equals `pin_in` after two synchronising flops, XOR the polarity word. It reflects a pin change at the second rising clock edge after the change.
- R4: When a polarity-adjusted input bit goes from 0 to 1, the matching edge-cause bit is set one edge later. It stays set, even after the input returns to 0, until software clears it.
- R5: Writing the edge-cause word clears every bit written as 0 and leaves every bit written as 1 unchanged. If a new edge arrives on a bit in the same cycle as a clearing write to that bit, the bit ends up set.
- R6: Pin k's cause is (input data[k] AND level enable[k]) OR (edge cause[k] AND edge enable[k]). `irq[g]` is the OR of the causes of pins 8g to 8g+7.
- R7: Reset clears drive level, blink, polarity, edge cause, edge enable and level enable, so all `irq` lines are low.
- R8: When an output pin has its blink bit set, `pin_out` is its drive-level bit XOR a square wave that changes every BLINK_HALF clocks. An input pin or a pin whose blink bit is clear shows only its drive-level bit.
- R9: Offsets with any address bit at position 5 or above set read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (8) | Byte address; bits 1:0 are ignored |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | NPINS (32) | Write data |
| reg_rdata | output | NPINS (32) | Read data for reg_addr |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Pin drive values |
| pin_oe | output | NPINS (32) | Pin output enables, 1 = drive |
| irq | output | NPINS/GROUP (4) | Grouped interrupt lines |

## Verification
The properties assume that `reg_addr`, `reg_we` and `reg_wdata` change only between clock edges. They also assume that each pin level stays put long enough for the synchroniser to catch it, so that edge causes come only from the adjusted input. The stimulus changes every input on the falling clock edge and holds each pin level for at least three clocks. It holds the pins low through reset and changes polarity only in ways whose edge effect the test expects. The same-cycle collision between an edge and a clearing write is produced by counting edges exactly from the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    RG_LEVEL  = 3'd0,
    RG_DIR    = 3'd1,
    RG_BLINK  = 3'd2,
    RG_POL    = 3'd3,
    RG_DIN    = 3'd4,
    RG_CAUSE  = 3'd5,
    RG_EMASK  = 3'd6,
    RG_LMASK  = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAP_TOP = SEL_LSB + SEL_W;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] adj,
  output logic [NPINS-1:0] rise
);
  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= adj;
    end
  end

  assign adj  = sync_q ^ pol;
  assign rise = adj & ~prev_q;
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int unsigned CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      wave  <= ~wave;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NPINS = 32,
  parameter int unsigned GROUP = 8
) (
  input  logic [NPINS-1:0]       pin_cause,
  output logic [NPINS/GROUP-1:0] irq
);
  localparam int unsigned NGROUP = NPINS / GROUP;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    assign irq[g] = |pin_cause[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS      = 32,
  parameter int unsigned GROUP      = 8,
  parameter int unsigned BLINK_HALF = 4,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [NPINS-1:0]         reg_wdata,
  output logic [NPINS-1:0]         reg_rdata,
  input  logic [NPINS-1:0]         pin_in,
  output logic [NPINS-1:0]         pin_out,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NPINS/GROUP-1:0]   irq
);
  localparam int unsigned NGROUP = NPINS / GROUP;

  logic [NPINS-1:0] r_level, r_dir, r_blink, r_pol;
  logic [NPINS-1:0] r_cause, r_emask, r_lmask;
  logic [NPINS-1:0] din, rise, pin_cause;
  logic             wave;
  logic             hit, wr_ok;
  reg_sel_e         sel;

  assign hit   = (reg_addr[ADDR_W-1:MAP_TOP] == '0);
  assign sel   = reg_sel_e'(reg_addr[MAP_TOP-1:SEL_LSB]);
  assign wr_ok = reg_we & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_level <= '0;
      r_dir   <= '1;
      r_blink <= '0;
      r_pol   <= '0;
      r_emask <= '0;
      r_lmask <= '0;
    end else if (wr_ok) begin
      case (sel)
        RG_LEVEL: r_level <= reg_wdata;
        RG_DIR:   r_dir   <= reg_wdata;
        RG_BLINK: r_blink <= reg_wdata;
        RG_POL:   r_pol   <= reg_wdata;
        RG_EMASK: r_emask <= reg_wdata;
        RG_LMASK: r_lmask <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // New edges are ORed in after the clear, so an edge beats a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cause <= '0;
    end else if (wr_ok && sel == RG_CAUSE) begin
      r_cause <= (r_cause & reg_wdata) | rise;
    end else begin
      r_cause <= r_cause | rise;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (sel)
        RG_LEVEL: reg_rdata = r_level;
        RG_DIR:   reg_rdata = r_dir;
        RG_BLINK: reg_rdata = r_blink;
        RG_POL:   reg_rdata = r_pol;
        RG_DIN:   reg_rdata = din;
        RG_CAUSE: reg_rdata = r_cause;
        RG_EMASK: reg_rdata = r_emask;
        RG_LMASK: reg_rdata = r_lmask;
        default:  reg_rdata = '0;
      endcase
    end
  end

  gpio_in_cond #(.NPINS(NPINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(r_pol),
    .adj(din), .rise(rise)
  );

  gpio_blink_div #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .wave(wave)
  );

  assign pin_oe    = ~r_dir;
  assign pin_out   = r_level ^ (r_blink & ~r_dir & {NPINS{wave}});
  assign pin_cause = (din & r_lmask) | (r_cause & r_emask);

  gpio_irq_merge #(.NPINS(NPINS), .GROUP(GROUP)) u_merge (
    .pin_cause(pin_cause), .irq(irq)
  );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NGROUP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [NPINS-1:0]  reg_wdata,
  input logic [NPINS-1:0]  reg_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NGROUP-1:0] irq,
  input logic [NPINS-1:0]  edge_cause,
  input logic [NPINS-1:0]  emask,
  input logic [NPINS-1:0]  lmask
);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(8'h14);

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> irq == '0); // R6

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq == '0); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_CAUSE) |=>
      ((edge_cause & $past(edge_cause)) == $past(edge_cause))); // R4

  AST_CAUSE_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CAUSE) |=>
      (($past(edge_cause & reg_wdata) & ~edge_cause) == '0)); // R5

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> pin_oe == ~$past(reg_wdata)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:5] != '0) |-> reg_rdata == '0); // R9
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .NGROUP(NPINS/GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe(pin_oe), .irq(irq),
  .edge_cause(r_cause), .emask(r_emask), .lmask(r_lmask)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int unsigned N = 32;
  localparam int unsigned HALF = 4;
  localparam logic [7:0] A_LEVEL = 8'h00, A_DIR = 8'h04, A_BLINK = 8'h08,
    A_POL = 8'h0C, A_DIN = 8'h10, A_CAUSE = 8'h14, A_EMASK = 8'h18, A_LMASK = 8'h1C;

  // {polarity, pins, expected input data}
  localparam logic [3*N-1:0] VEC [4] = '{
    {32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF},
    {32'hFFFF_0000, 32'h0000_00FF, 32'hFFFF_00FF},
    {32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hF0F0_F0F0},
    {32'hAAAA_AAAA, 32'h5555_0000, 32'hFFFF_AAAA}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0, pin_in = '0, reg_rdata, pin_out, pin_oe;
  logic [3:0] irq;
  int checks = 0, errors = 0;
  logic [N-1:0] v;

  always #4 clk = ~clk;

  gpio_irq_unit #(.NPINS(N), .GROUP(8), .BLINK_HALF(HALF), .ADDR_W(8)) u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pins(input logic [N-1:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R7 / R2 reset state
    rd(A_CAUSE, v); chk("R7 cause", v, '0);
    rd(A_EMASK, v); chk("R7 emask", v, '0);
    rd(A_LMASK, v); chk("R7 lmask", v, '0);
    rd(A_LEVEL, v); chk("R7 level", v, '0);
    chk("R7 irq", {28'd0, irq}, '0);
    rd(A_DIR, v);   chk("R2 dir reset", v, '1);
    chk("R2 oe reset", pin_oe, '0);

    // R3 vector table
    foreach (VEC[i]) begin
      wr(A_POL, VEC[i][3*N-1:2*N]);
      pins(VEC[i][2*N-1:N]);
      rd(A_DIN, v);
      chk("R3 din", v, VEC[i][N-1:0]);
    end
    wr(A_POL, '0); pins('0); wr(A_CAUSE, '0);
    rd(A_CAUSE, v); chk("R5 clear all", v, '0);

    // R1 readback and read-only data word
    wr(A_BLINK, 32'h1234_5678); rd(A_BLINK, v); chk("R1 blink rb", v, 32'h1234_5678);
    wr(A_BLINK, '0);
    wr(A_DIN, '1); rd(A_DIN, v); chk("R1 din ro", v, '0);

    // R2 direction and drive
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_LEVEL, 32'hA5A5_3C3C);
    chk("R2 oe", pin_oe, 32'hFFFF_0000);
    chk("R2 out", {16'd0, pin_out[31:16]}, 32'h0000_A5A5);
    rd(A_LEVEL, v); chk("R1 level rb", v, 32'hA5A5_3C3C);

    // R9 unmapped
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, v); chk("R9 read 0x20", v, '0);
    rd(8'h40, v); chk("R9 read 0x40", v, '0);
    rd(A_LEVEL, v); chk("R9 write ignored", v, 32'hA5A5_3C3C);
    wr(A_DIR, '1); wr(A_LEVEL, '0);

    // R4 / R5 / R6 edge path on pin 3
    pins(32'h0000_0008);
    rd(A_CAUSE, v); chk("R4 rise sets", v, 32'h8);
    chk("R6 masked", {28'd0, irq}, '0);
    wr(A_EMASK, 32'h8);
    chk("R6 irq0", {28'd0, irq}, 32'h1);
    pins('0);
    rd(A_CAUSE, v); chk("R4 sticky", v, 32'h8);
    wr(A_CAUSE, '1); rd(A_CAUSE, v); chk("R5 ones keep", v, 32'h8);
    wr(A_CAUSE, 32'hFFFF_FFF7); rd(A_CAUSE, v); chk("R5 zero clears", v, '0);
    chk("R6 irq gone", {28'd0, irq}, '0);
    wr(A_EMASK, '0);

    // R4 falling edge through polarity on pin 9
    pins(32'h0000_0200);
    wr(A_POL, 32'h0000_0200);
    wr(A_CAUSE, '0);
    rd(A_CAUSE, v); chk("R4 no edge on pol", v, '0);
    wr(A_EMASK, 32'h0000_0200);
    pins('0);
    rd(A_CAUSE, v); chk("R4 falling", v, 32'h0000_0200);
    chk("R6 irq1", {28'd0, irq}, 32'h2);
    wr(A_EMASK, '0); wr(A_POL, '0); wr(A_CAUSE, '0);

    // R6 level path
    wr(A_LMASK, 32'h8010_0000);
    pins(32'h0010_0000);
    chk("R6 level irq2", {28'd0, irq}, 32'h4);
    pins('0);
    chk("R6 level drop", {28'd0, irq}, '0);
    wr(A_POL, 32'h8000_0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 active-low irq3", {28'd0, irq}, 32'h8);
    wr(A_LMASK, '0); wr(A_POL, '0); wr(A_CAUSE, '0);

    // R5 collision: pin 13 pending, pin 12 rises in the clearing-write cycle
    pins(32'h0000_2000);
    @(negedge clk) pin_in = 32'h0000_3000;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) begin reg_addr = A_CAUSE; reg_wdata = '0; reg_we = 1'b1; end
    @(posedge clk);
    @(negedge clk) reg_we = 1'b0;
    rd(A_CAUSE, v); chk("R5 edge beats clear", v, 32'h0000_1000);
    pins('0); wr(A_CAUSE, '0);

    // R8 blink: pin 0 output blinking, pin 1 input with blink bit
    wr(A_DIR, 32'hFFFF_FFFE);
    wr(A_BLINK, 32'h3);
    begin
      logic p0, in_moved;
      int k;
      in_moved = 1'b0;
      @(negedge clk) p0 = pin_out[0];
      for (int j = 0; j < 20 && pin_out[0] == p0; j++) begin
        @(negedge clk);
        if (pin_out[1]) in_moved = 1'b1;
      end
      p0 = pin_out[0];
      k = 0;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        k++;
        if (pin_out[1]) in_moved = 1'b1;
        if (pin_out[0] != p0) break;
      end
      chk("R8 half period", 32'(k), 32'(HALF));
      chk("R8 input pin quiet", {31'd0, in_moved}, '0);
    end
    wr(A_BLINK, '0);
    wr(A_LEVEL, 32'h1);
    repeat (HALF) begin
      @(negedge clk);
      chk("R8 blink off", {31'd0, pin_out[0]}, 32'h1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule